// File: doc/BRIEF.md
# HDLC Receive Framer with Status FIFO

This block turns a serial bit stream carried in bit-oriented synchronous framing into stored characters. Each character goes into a data FIFO, and a matching entry goes into a status FIFO. The status entry says whether the character closes a frame, whether the frame was aborted, how many of its bits are valid, and whether earlier characters were lost to a full buffer. Bits arrive one per cycle of `clk` on which `rx_valid` is high, least significant bit first. Software or a downstream engine pops the two FIFOs with separate read strobes and can watch `irq` to learn that the final character of a frame is waiting.

The block is built from two state machines. The line state machine has two states. In `ST_HUNT` it ignores everything except a flag, which moves it to `ST_FRAME` (transition *open*). In `ST_FRAME` a flag closes the current frame and opens the next one, staying in `ST_FRAME` (transition *close/reopen*). Seven ones in a row move it back to `ST_HUNT` (transition *abort*). The line machine also deletes stuffed zeros. Every surviving bit passes through a seven-bit hold-back window, so that the bits of a closing flag or an abort never reach a character.

The character state machine has three states. `AS_EMPTY` means no bit of the current frame has been committed yet. `AS_PART` means a character is being filled. `AS_HELD` means a complete character is waiting to learn whether it is the last one in the frame. Its transitions are:
- *start*: the first committed bit moves `AS_EMPTY` to `AS_PART`.
- *fill*: `AS_PART` stays in `AS_PART` while the character is not yet full.
- *complete*: the eighth bit moves `AS_PART` to `AS_HELD`.
- *release*: the next committed bit writes the held character out and moves `AS_HELD` to `AS_PART`.
- *finish*: a flag or an abort writes any pending character as the frame's last and returns to `AS_EMPTY`.

Top module: `hdlc_rx_framer`

## Requirements
- R1: In `ST_HUNT` no bit is stored until the pattern 01111110 is seen. After that flag, the bits up to the next flag are packed into characters. The first bit received of each character lands in bit 0 of `data_out`.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed and does not occupy a bit position in any character.
- R3: Every stored character has one status entry. `stat_out` is laid out as bit 5 overrun, bit 4 abort, bit 3 end-of-message, and bits 2:0 the count of valid bits, where 0 means all 8. Characters that are not the last one in their frame read 0 in bits 4:0. The last character of a flag-closed frame has end-of-message 1 and abort 0. Its count gives the number of bits received in that character, and only bits below that count are defined.
- R4: Seven consecutive 1s inside a frame abort it. The bits still in the seven-bit hold-back window are dropped: the last data bit before the abort run and the run's own 1s. The character being filled is written with its committed bit count and with both end-of-message and abort set. If no partial bit exists, the last complete character is written that way with count 0.
- R5: A flag with no committed bits since the previous flag writes nothing. This covers idle flags and back-to-back flags.
- R6: `irq` is high exactly when the status FIFO is non-empty, its head entry has end-of-message set, and either that entry has abort set and `ie_abort` is 1, or it has abort clear with a non-zero count and `ie_resid` is 1. A full-length normal last character never raises `irq`.
- R7: After an abort the block discards all input until the next flag. The frame that follows starts with no leftover bits.
- R8: A character that must be written while either FIFO is full is dropped. The next entry that is written has the overrun bit set, and the entry after that has it clear again.
- R9: `data_rd` and `stat_rd` each pop only their own FIFO, one entry per strobe. A strobe on an empty FIFO has no effect.
- R10: After reset both FIFOs are empty, `irq` is low and the line machine hunts for a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Qualifies `rx_data` as one line bit this cycle |
| rx_data | input | 1 | Serial line bit |
| data_rd | input | 1 | Pop the data FIFO |
| stat_rd | input | 1 | Pop the status FIFO |
| ie_resid | input | 1 | Interrupt enable for a short last character of a normally closed frame |
| ie_abort | input | 1 | Interrupt enable for an aborted frame's last character |
| data_out | output | 8 | Head of the data FIFO |
| data_empty | output | 1 | Data FIFO holds no entry |
| stat_out | output | 6 | Head of the status FIFO: overrun, abort, end-of-message, bit count |
| stat_empty | output | 1 | Status FIFO holds no entry |
| irq | output | 1 | Last character of a frame is ready and its interrupt is enabled |

## Verification
The bench sweeps every byte value through two-byte frames, so all stuffing positions are hit. A design that deleted the wrong zero, or failed to delete one, would shift bits and corrupt bytes next to runs of ones. It then sweeps every short last character of one to seven bits, and every abort point after zero to seven committed bits. A design that leaked flag or abort ones into a character, miscounted residual bits, or tagged the wrong entry with end-of-message would show a wrong count or a wrong data value. Further checks fill the FIFOs until a character is dropped, then look for the overrun mark on exactly one following entry. They also confirm that input after an abort is ignored until a flag, and that `irq` follows the enables for the head entry only.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    // character geometry
    localparam int CHAR_W  = 8;
    localparam int RES_W   = $clog2(CHAR_W);
    // bits withheld so a closing flag or abort run never reaches a character
    localparam int HOLD_W  = CHAR_W - 1;
    localparam int HCNT_W  = $clog2(HOLD_W + 1);
    localparam int ONES_W  = 3;

    // status word layout, high to low: overrun, abort, end-of-message, count
    typedef struct packed {
        logic             ovr;
        logic             abt;
        logic             eom;
        logic [RES_W-1:0] resid;
    } rx_stat_t;

    localparam int STAT_W  = $bits(rx_stat_t);
    localparam int BIT_EOM = RES_W;
    localparam int BIT_ABT = RES_W + 1;

    typedef enum logic {
        ST_HUNT,
        ST_FRAME
    } line_state_t;

    typedef enum logic [1:0] {
        AS_EMPTY,
        AS_PART,
        AS_HELD
    } asm_state_t;

endpackage

// File: rtl/hdlc_rx_linefsm.sv
module hdlc_rx_linefsm
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rx_data,
    output logic ev_bit,
    output logic ev_bit_val,
    output logic ev_flag,
    output logic ev_abort,
    output logic in_frame
);

    localparam logic [ONES_W-1:0] ONES_STUFF = ONES_W'(5);
    localparam logic [ONES_W-1:0] ONES_SIX   = ONES_W'(6);
    localparam logic [ONES_W-1:0] ONES_SAT   = ONES_W'(7);

    line_state_t        state_q, state_d;
    logic [ONES_W-1:0]  ones_q;
    logic               saw_flag, saw_stuff, saw_abort;

    // pattern recognition on the raw line
    always_comb begin
        saw_flag  = rx_valid && !rx_data && (ones_q == ONES_SIX);
        saw_stuff = rx_valid && !rx_data && (ones_q == ONES_STUFF);
        saw_abort = rx_valid &&  rx_data && (ones_q == ONES_SIX);
    end

    // run length of ones, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (rx_valid) begin
            if (!rx_data)
                ones_q <= '0;
            else if (ones_q != ONES_SAT)
                ones_q <= ones_q + ONES_W'(1);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (saw_flag)
                    state_d = ST_FRAME;
            end
            ST_FRAME: begin
                if (saw_abort)
                    state_d = ST_HUNT;
                else if (saw_flag)
                    state_d = ST_FRAME;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_HUNT;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        ev_bit     = 1'b0;
        ev_bit_val = rx_data;
        ev_flag    = saw_flag;
        ev_abort   = 1'b0;
        in_frame   = (state_q == ST_FRAME);
        unique case (state_q)
            ST_HUNT: begin
                ev_bit = 1'b0;
            end
            ST_FRAME: begin
                ev_abort = saw_abort;
                ev_bit   = rx_valid && !saw_flag && !saw_stuff && !saw_abort;
            end
            default: ev_bit = 1'b0;
        endcase
    end

    AST_HUNT_NO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |-> !ev_bit);  // R7
    AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_bit, ev_flag, ev_abort}));  // R1
    AST_ABORT_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort |=> !in_frame);  // R7
    AST_STUFF_DELETED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_data && in_frame && $past(rx_valid && rx_data)) && ev_bit |-> !saw_stuff);  // R2

endmodule

// File: rtl/hdlc_rx_charasm.sv
module hdlc_rx_charasm
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_bit,
    input  logic              ev_bit_val,
    input  logic              ev_flag,
    input  logic              ev_abort,
    input  logic              fifo_full,
    output logic              wr_en,
    output logic [CHAR_W-1:0] wr_data,
    output rx_stat_t          wr_stat
);

    localparam logic [HCNT_W-1:0] HOLD_FULL = HCNT_W'(HOLD_W);
    localparam logic [RES_W-1:0]  LAST_IDX  = RES_W'(CHAR_W - 1);

    asm_state_t          state_q, state_d;
    logic [HOLD_W-1:0]   hold_q;
    logic [HCNT_W-1:0]   hold_cnt_q;
    logic [CHAR_W-1:0]   char_q, held_q, char_new;
    logic [RES_W-1:0]    bit_cnt_q, idx;
    logic                ovr_pend_q;
    logic                commit, commit_val, frame_end, push_req;
    logic [CHAR_W-1:0]   push_data;
    rx_stat_t            push_stat;

    assign frame_end  = ev_flag || ev_abort;
    assign commit     = ev_bit && (hold_cnt_q == HOLD_FULL);
    assign commit_val = hold_q[HOLD_W-1];

    // hold-back window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            hold_cnt_q <= '0;
        end else if (frame_end) begin
            hold_cnt_q <= '0;
        end else if (ev_bit) begin
            hold_q <= {hold_q[HOLD_W-2:0], ev_bit_val};
            if (hold_cnt_q != HOLD_FULL)
                hold_cnt_q <= hold_cnt_q + HCNT_W'(1);
        end
    end

    // character under construction after this commit
    always_comb begin
        idx      = (state_q == AS_PART) ? bit_cnt_q : '0;
        char_new = (state_q == AS_PART) ? char_q : '0;
        char_new[idx] = commit_val;
    end

    // next state and write request
    always_comb begin
        state_d   = state_q;
        push_req  = 1'b0;
        push_data = '0;
        push_stat = '0;
        if (frame_end) begin
            state_d = AS_EMPTY;
            unique case (state_q)
                AS_PART: begin
                    push_req        = 1'b1;
                    push_data       = char_q;
                    push_stat.resid = bit_cnt_q;
                    push_stat.eom   = 1'b1;
                    push_stat.abt   = ev_abort;
                end
                AS_HELD: begin
                    push_req      = 1'b1;
                    push_data     = held_q;
                    push_stat.eom = 1'b1;
                    push_stat.abt = ev_abort;
                end
                default: push_req = 1'b0;
            endcase
        end else if (commit) begin
            unique case (state_q)
                AS_EMPTY: state_d = AS_PART;
                AS_PART:  state_d = (bit_cnt_q == LAST_IDX) ? AS_HELD : AS_PART;
                AS_HELD: begin
                    push_req  = 1'b1;
                    push_data = held_q;
                    state_d   = AS_PART;
                end
                default:  state_d = AS_EMPTY;
            endcase
        end
        push_stat.ovr = ovr_pend_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= AS_EMPTY;
        else
            state_q <= state_d;
    end

    // character datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q    <= '0;
            held_q    <= '0;
            bit_cnt_q <= '0;
        end else if (frame_end) begin
            char_q    <= '0;
            bit_cnt_q <= '0;
        end else if (commit) begin
            if ((state_q == AS_PART) && (bit_cnt_q == LAST_IDX)) begin
                held_q    <= char_new;
                char_q    <= '0;
                bit_cnt_q <= '0;
            end else begin
                char_q    <= char_new;
                bit_cnt_q <= idx + RES_W'(1);
            end
        end
    end

    // overrun carried to the next accepted entry
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_pend_q <= 1'b0;
        else if (push_req)
            ovr_pend_q <= fifo_full;
    end

    // outputs
    always_comb begin
        wr_en   = push_req && !fifo_full;
        wr_data = push_data;
        wr_stat = push_stat;
    end

    AST_END_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (state_q == AS_EMPTY) && (hold_cnt_q == '0));  // R7
    AST_MID_FULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_stat.eom |-> (wr_stat.resid == '0) && !wr_stat.abt);  // R3
    AST_ABORT_IS_END: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_stat.abt |-> wr_stat.eom);  // R4
    AST_OVR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !ovr_pend_q);  // R8

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             do_wr, do_rd;

    assign empty   = (count_q == '0);
    assign full    = (count_q == CNT_FULL);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wr_ptr_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_wr)
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + PTR_W'(1);
            if (do_rd)
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + PTR_W'(1);
            if (do_wr && !do_rd)
                count_q <= count_q + CNT_W'(1);
            else if (do_rd && !do_wr)
                count_q <= count_q - CNT_W'(1);
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full && !rd_en |=> full);  // R8
    AST_FIFO_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        empty && !wr_en |=> empty);  // R9

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
    import hdlc_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic                rx_data,
    input  logic                data_rd,
    input  logic                stat_rd,
    input  logic                ie_resid,
    input  logic                ie_abort,
    output logic [CHAR_W-1:0]   data_out,
    output logic                data_empty,
    output logic [STAT_W-1:0]   stat_out,
    output logic                stat_empty,
    output logic                irq
);

    logic              ev_bit, ev_bit_val, ev_flag, ev_abort, in_frame;
    logic              wr_en, data_full, stat_full, fifo_full;
    logic [CHAR_W-1:0] wr_data;
    rx_stat_t          wr_stat;
    logic [STAT_W-1:0] wr_stat_bits;
    logic              head_eom, head_abt;
    logic [RES_W-1:0]  head_resid;

    hdlc_rx_linefsm u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .ev_bit     (ev_bit),
        .ev_bit_val (ev_bit_val),
        .ev_flag    (ev_flag),
        .ev_abort   (ev_abort),
        .in_frame   (in_frame)
    );

    assign fifo_full = data_full || stat_full;

    hdlc_rx_charasm u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_bit     (ev_bit),
        .ev_bit_val (ev_bit_val),
        .ev_flag    (ev_flag),
        .ev_abort   (ev_abort),
        .fifo_full  (fifo_full),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_stat    (wr_stat)
    );

    assign wr_stat_bits = wr_stat;

    hdlc_rx_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_data_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (data_rd),
        .rd_data (data_out),
        .empty   (data_empty),
        .full    (data_full)
    );

    hdlc_rx_fifo #(.WIDTH(STAT_W), .DEPTH(FIFO_DEPTH)) u_stat_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_stat_bits),
        .rd_en   (stat_rd),
        .rd_data (stat_out),
        .empty   (stat_empty),
        .full    (stat_full)
    );

    // interrupt from the status entry at the head
    assign head_eom   = stat_out[BIT_EOM];
    assign head_abt   = stat_out[BIT_ABT];
    assign head_resid = stat_out[RES_W-1:0];

    always_comb begin
        irq = !stat_empty && head_eom &&
              ((head_abt && ie_abort) || (!head_abt && (head_resid != '0) && ie_resid));
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie_resid || ie_abort));  // R6
    AST_IRQ_HEAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !stat_empty);  // R6
    AST_NO_WRITE_IN_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame && !$past(in_frame) |-> !wr_en);  // R7
    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> data_empty && stat_empty);  // R10

endmodule

// File: tb/test_hdlc_rx_framer.sv
`timescale 1ns/1ps
module test_hdlc_rx_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic       rx_data = 1'b0;
    logic       data_rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic       ie_resid = 1'b0;
    logic       ie_abort = 1'b0;
    logic [7:0] data_out;
    logic       data_empty;
    logic [5:0] stat_out;
    logic       stat_empty;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int tx_ones = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hdlc_rx_framer #(.FIFO_DEPTH(4)) i_hdlc_rx_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .data_rd    (data_rd),
        .stat_rd    (stat_rd),
        .ie_resid   (ie_resid),
        .ie_abort   (ie_abort),
        .data_out   (data_out),
        .data_empty (data_empty),
        .stat_out   (stat_out),
        .stat_empty (stat_empty),
        .irq        (irq)
    );

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // all stimulus tasks start and end on a falling edge
    task automatic send_raw(input logic b);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        repeat (6) send_raw(1'b1);
        send_raw(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_abort();
        repeat (7) send_raw(1'b1);
        tx_ones = 0;
    endtask

    task automatic send_data_bit(input logic b);
        send_raw(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_raw(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) send_data_bit(v[i]);
    endtask

    task automatic expect_entry(input string req, input logic [7:0] exp_d, input int nbits,
                                input logic abt, input logic eom, input logic ovr);
        logic [7:0] mask;
        logic [5:0] exp_s;
        logic       exp_irq;
        mask    = (nbits == 0) ? 8'hFF : 8'((1 << nbits) - 1);
        exp_s   = {ovr, abt, eom, 3'(nbits)};
        exp_irq = eom && ((abt && ie_abort) || (!abt && (nbits != 0) && ie_resid));
        check({req, " data present"}, int'(data_empty), 0);
        check({req, " status present"}, int'(stat_empty), 0);
        check({req, " data"}, int'(data_out & mask), int'(exp_d & mask));
        check({req, " status"}, int'(stat_out), int'(exp_s));
        check({req, " R6 irq"}, int'(irq), int'(exp_irq));
        data_rd = 1'b1;
        stat_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        stat_rd = 1'b0;
    endtask

    task automatic expect_none(input string req);
        check({req, " data empty"}, int'(data_empty), 1);
        check({req, " status empty"}, int'(stat_empty), 1);
        check({req, " irq low"}, int'(irq), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        expect_none("R10 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1 hunting: ones and zeros without a flag store nothing
        send_bits(8'h3C, 8);
        send_bits(8'h00, 8);
        repeat (3) @(negedge clk);
        expect_none("R1 hunt ignores data");

        // R5 idle flags
        send_flag();
        send_flag();
        send_flag();
        expect_none("R5 idle flags");

        // R9 read strobes on empty FIFOs are ignored
        data_rd = 1'b1;
        stat_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        stat_rd = 1'b0;
        send_flag();
        send_bits(8'h5A, 8);
        send_flag();
        expect_entry("R9 empty read", 8'h5A, 0, 1'b0, 1'b1, 1'b0);
        expect_none("R9 after single");

        // R9 independent pops
        send_flag();
        send_bits(8'hA1, 8);
        send_bits(8'h7E, 8);
        send_flag();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check("R9 status popped alone", int'(stat_out), int'(6'b001000));
        check("R9 data kept", int'(data_out), 'hA1);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        check("R9 data popped alone", int'(data_out), 'h7E);
        expect_entry("R9 second pop", 8'h7E, 0, 1'b0, 1'b1, 1'b0);
        expect_none("R9 drained");

        // R1 R2 R3: every byte value, with its complement, as a two-byte frame
        ie_resid = 1'b1;
        ie_abort = 1'b1;
        for (int v = 0; v < 256; v++) begin
            send_flag();
            send_bits(8'(v), 8);
            send_bits(~8'(v), 8);
            send_flag();
            expect_entry("R1 R2 first byte", 8'(v), 0, 1'b0, 1'b0, 1'b0);
            expect_entry("R3 last full byte", ~8'(v), 0, 1'b0, 1'b1, 1'b0);
        end
        expect_none("R3 sweep drained");

        // R3 R6: every short last character
        for (int k = 1; k < 8; k++) begin
            for (int p = 0; p < (1 << k); p++) begin
                ie_resid = p[0];
                ie_abort = 1'b1;
                send_flag();
                send_bits(8'(p) ^ 8'h3C, 8);
                send_bits(8'(p), k);
                send_flag();
                expect_entry("R3 lead byte", 8'(p) ^ 8'h3C, 0, 1'b0, 1'b0, 1'b0);
                expect_entry("R3 residual", 8'(p), k, 1'b0, 1'b1, 1'b0);
            end
        end
        expect_none("R3 residual drained");

        // R4 R6 R7: abort after every count of committed bits
        for (int m = 0; m < 8; m++) begin
            for (int q = 0; q < (1 << m); q++) begin
                ie_resid = 1'b1;
                ie_abort = (m == 0) ? 1'b1 : q[0];
                send_flag();
                send_bits(8'(q) ^ 8'hC3, 8);
                send_bits(8'(q), m);
                send_data_bit(1'b0);
                send_abort();
                // R7 input after an abort is discarded until a flag
                send_raw(1'b0);
                send_raw(1'b1);
                send_raw(1'b1);
                send_raw(1'b0);
                if (m == 0) begin
                    expect_entry("R4 abort on held byte", 8'(q) ^ 8'hC3, 0, 1'b1, 1'b1, 1'b0);
                end else begin
                    expect_entry("R4 lead byte", 8'(q) ^ 8'hC3, 0, 1'b0, 1'b0, 1'b0);
                    expect_entry("R4 abort partial", 8'(q), m, 1'b1, 1'b1, 1'b0);
                end
                expect_none("R7 nothing after abort");
            end
        end

        // R7 new frame after abort starts clean
        send_flag();
        send_bits(8'h81, 8);
        send_flag();
        expect_entry("R7 clean restart", 8'h81, 0, 1'b0, 1'b1, 1'b0);

        // R6 enables off: no interrupt on aborted or residual last characters
        ie_resid = 1'b0;
        ie_abort = 1'b0;
        send_flag();
        send_bits(8'h15, 5);
        send_flag();
        expect_entry("R6 residual disabled", 8'h15, 5, 1'b0, 1'b1, 1'b0);
        send_flag();
        send_bits(8'h0B, 4);
        send_data_bit(1'b0);
        send_abort();
        expect_entry("R6 abort disabled", 8'h0B, 4, 1'b1, 1'b1, 1'b0);

        // R8 overrun: six bytes into a four-deep buffer
        send_flag();
        for (int i = 0; i < 6; i++) send_bits(8'(i * 17 + 3), 8);
        send_flag();
        for (int i = 0; i < 4; i++)
            expect_entry("R8 kept byte", 8'(i * 17 + 3), 0, 1'b0, 1'b0, 1'b0);
        expect_none("R8 dropped bytes");
        send_flag();
        send_bits(8'h42, 8);
        send_flag();
        expect_entry("R8 overrun marked", 8'h42, 0, 1'b0, 1'b1, 1'b1);
        send_flag();
        send_bits(8'h24, 8);
        send_flag();
        expect_entry("R8 overrun cleared", 8'h24, 0, 1'b0, 1'b1, 1'b0);
        expect_none("R8 drained");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule